// File: doc/BRIEF.md
# Serial control transaction sequencer

This block sits on the controller side of a low-speed sideband link that is used to configure memory devices. It takes one high-level command at a time through a ready/valid interface and turns it into a framed serial transaction. Each transaction starts with a framing burst on a dedicated command line. Fixed-width packets then follow, one bit per clock, most significant bit first, on a serial data line.

Register reads and writes produce four packets: request, address, interval and data. The initialization commands produce a request packet only. After each initialization command the sequencer holds the link idle for the mandatory number of cycles. A reset command always produces a set-reset transaction and then a clear-reset transaction, with the long gap between them. During the data packet of a read the sequencer releases the data line and shifts in the returned word. It then presents that word with a one-cycle response strobe.

Top module: `sctl_seq`

## Requirements
- R1: Out of reset and whenever no command is in progress, `cmd_ready_o` is 1, `ser_cmd_o` is 0, `ser_do_o` is 0, `ser_oe_o` is 1 and `rsp_valid_o` is 0.
- R2: Counting the cycle after the accepting clock edge as cycle 0, `ser_cmd_o` is 1 in cycles 0–3 and 0 in cycles 4–7. It is 0 for the rest of the transaction.
- R3: The request packet is driven MSB first in cycles 8–23. Bits 15:11 are 0, bit 10 is device ID bit 5, bits 9:6 are the opcode, bit 5 is the broadcast flag and bits 4:0 are device ID bits 4:0.
- R4: Host command codes on `cmd_op_i` are 0 = register read, 1 = register write, 2 = reset pair and 3 = fast clock. The line opcodes are 0000 for read, 0001 for write, 0010 for set-reset, 1011 for clear-reset and 0100 for fast clock.
- R5: Reads and writes follow the request with an address packet in cycles 24–39 (bits 15:12 zero, 11:0 address), an all-zero interval packet in cycles 40–55 and a data packet in cycles 56–71. For a write, the data packet carries `cmd_wdata_i` MSB first.
- R6: During a read, `ser_oe_o` is 0 in cycles 56–71 only. The sequencer samples `ser_di_i` at the end of each of those cycles, MSB first. In cycle 72 `rsp_valid_o` pulses for exactly one cycle with the captured word on `rsp_data_o`.
- R7: A fast-clock command emits only its request packet, keeps the link idle in cycles 24–27 and raises `cmd_ready_o` in cycle 28.
- R8: A reset-pair command emits a set-reset transaction. The link is then idle in cycles 24–39. A complete clear-reset transaction follows, with framing in cycles 40–47 and the request in cycles 48–63. The link is then idle in cycles 64–67, and `cmd_ready_o` returns in cycle 68.
- R9: `cmd_ready_o` falls in the cycle after acceptance and stays 0 until the transaction and its gap finish. A read or write makes it 1 again in cycle 72. `cmd_valid_i` asserted while `cmd_ready_o` is 0 is ignored and leaves the serial outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Sequencer can accept a command |
| cmd_op_i | input | 2 | Host command code |
| cmd_dev_i | input | 6 | Target device ID |
| cmd_bcast_i | input | 1 | Broadcast flag |
| cmd_addr_i | input | 12 | Register address |
| cmd_wdata_i | input | 16 | Write data |
| ser_cmd_o | output | 1 | Framing command line |
| ser_do_o | output | 1 | Serial data out |
| ser_oe_o | output | 1 | Data line drive enable |
| ser_di_i | input | 1 | Serial data in |
| rsp_valid_o | output | 1 | Read word valid strobe |
| rsp_data_o | output | 16 | Captured read word |

## Verification
The bench builds the block with its default parameters: 16-bit packets, four-cycle framing halves, a long gap of 16 cycles and a short gap of 4 cycles. With these values every cycle boundary in R2–R8 lands at a fixed offset from acceptance, so the bench checks each packet, gap and ready edge at an exact cycle number. The long gap is short enough that the full reset pair, clear-reset framing included, fits in one capture window.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  typedef enum logic [1:0] {
    HC_READ  = 2'd0,
    HC_WRITE = 2'd1,
    HC_RSTPR = 2'd2,
    HC_FAST  = 2'd3
  } host_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_SHIFT = 2'd2,
    ST_GAP   = 2'd3
  } seq_state_e;

  localparam logic [3:0] OPC_READ  = 4'b0000;
  localparam logic [3:0] OPC_WRITE = 4'b0001;
  localparam logic [3:0] OPC_SETR  = 4'b0010;
  localparam logic [3:0] OPC_FAST  = 4'b0100;
  localparam logic [3:0] OPC_CLRR  = 4'b1011;

  localparam logic [1:0] PK_REQ  = 2'd0;
  localparam logic [1:0] PK_ADDR = 2'd1;
  localparam logic [1:0] PK_IVL  = 2'd2;
  localparam logic [1:0] PK_DATA = 2'd3;

endpackage

// File: rtl/sctl_pkt_build.sv
module sctl_pkt_build #(
  parameter int PKT_W  = 16,
  parameter int DEV_W  = 6,
  parameter int ADDR_W = 12
) (
  input  logic [1:0]        pkt_sel_i,
  input  logic [3:0]        opc_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic              bcast_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PKT_W-1:0]  wdata_i,
  output logic [PKT_W-1:0]  word_o
);
  import sctl_pkg::*;

  localparam int REQ_USED = DEV_W + 4 + 1;

  logic [PKT_W-1:0] req_w;
  logic [PKT_W-1:0] addr_w;

  // Request layout: upper device bit, opcode, broadcast, low device bits.
  always_comb begin
    req_w = '0;
    req_w[REQ_USED-1 -: 1]   = dev_i[DEV_W-1];
    req_w[REQ_USED-2 -: 4]   = opc_i;
    req_w[DEV_W-1]           = bcast_i;
    req_w[DEV_W-2:0]         = dev_i[DEV_W-2:0];
  end

  always_comb begin
    addr_w = '0;
    addr_w[ADDR_W-1:0] = addr_i;
  end

  always_comb begin
    unique case (pkt_sel_i)
      PK_REQ:  word_o = req_w;
      PK_ADDR: word_o = addr_w;
      PK_IVL:  word_o = '0;
      default: word_o = wdata_i;
    endcase
  end

endmodule

// File: rtl/sctl_gap_timer.sv
module sctl_gap_timer #(
  parameter int GAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [GAP_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [GAP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                     cnt_d = load_val_i;
    else if (run_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sctl_rx_shift.sv
module sctl_rx_shift #(
  parameter int PKT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             din_i,
  output logic [PKT_W-1:0] word_o
);
  logic [PKT_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (en_i) sh_d = {sh_q[PKT_W-2:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word_o = sh_q;

endmodule

// File: rtl/sctl_seq.sv
module sctl_seq #(
  parameter int PKT_W      = 16,
  parameter int DEV_W      = 6,
  parameter int ADDR_W     = 12,
  parameter int FRAME_HALF = 4,
  parameter int GAP_LONG   = 16,
  parameter int GAP_SHORT  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [1:0]        cmd_op_i,
  input  logic [DEV_W-1:0]  cmd_dev_i,
  input  logic              cmd_bcast_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [PKT_W-1:0]  cmd_wdata_i,
  output logic              ser_cmd_o,
  output logic              ser_do_o,
  output logic              ser_oe_o,
  input  logic              ser_di_i,
  output logic              rsp_valid_o,
  output logic [PKT_W-1:0]  rsp_data_o
);
  import sctl_pkg::*;

  localparam int CNT_W  = $clog2(PKT_W);
  localparam int GAP_W  = $clog2(GAP_LONG + 1);
  localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(PKT_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(2 * FRAME_HALF - 1);
  localparam logic [CNT_W-1:0] FRAME_HI   = CNT_W'(FRAME_HALF);
  localparam logic [GAP_W-1:0] GAP_L_LD   = GAP_W'(GAP_LONG - 1);
  localparam logic [GAP_W-1:0] GAP_S_LD   = GAP_W'(GAP_SHORT - 1);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [1:0]        pkt_q, pkt_d;
  logic [3:0]        opc_q, opc_d;
  logic [DEV_W-1:0]  dev_q, dev_d;
  logic              bc_q, bc_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [PKT_W-1:0]  wd_q, wd_d;
  logic              rw_q, rw_d;
  logic              rd_q, rd_d;
  logic              pair_q, pair_d;
  logic              rsp_q, rsp_d;

  logic              accept;
  logic              last_bit;
  logic              last_pkt;
  logic              rx_phase;
  logic              gap_load;
  logic [GAP_W-1:0]  gap_val;
  logic              gap_done;
  logic [PKT_W-1:0]  cur_word;

  assign accept   = cmd_valid_i && (st_q == ST_IDLE);
  assign last_bit = (cnt_q == BIT_LAST);
  assign last_pkt = rw_q ? (pkt_q == PK_DATA) : (pkt_q == PK_REQ);
  assign rx_phase = (st_q == ST_SHIFT) && rd_q && (pkt_q == PK_DATA);

  sctl_pkt_build #(.PKT_W(PKT_W), .DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_build (
    .pkt_sel_i (pkt_q),
    .opc_i     (opc_q),
    .dev_i     (dev_q),
    .bcast_i   (bc_q),
    .addr_i    (addr_q),
    .wdata_i   (wd_q),
    .word_o    (cur_word)
  );

  sctl_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (gap_load),
    .load_val_i (gap_val),
    .run_i      (st_q == ST_GAP),
    .done_o     (gap_done)
  );

  sctl_rx_shift #(.PKT_W(PKT_W)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (rx_phase),
    .din_i  (ser_di_i),
    .word_o (rsp_data_o)
  );

  // Next-state logic
  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    pkt_d    = pkt_q;
    opc_d    = opc_q;
    dev_d    = dev_q;
    bc_d     = bc_q;
    addr_d   = addr_q;
    wd_d     = wd_q;
    rw_d     = rw_q;
    rd_d     = rd_q;
    pair_d   = pair_q;
    rsp_d    = rx_phase && last_bit;
    gap_load = 1'b0;
    gap_val  = GAP_S_LD;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_FRAME;
          cnt_d  = '0;
          pkt_d  = PK_REQ;
          dev_d  = cmd_dev_i;
          bc_d   = cmd_bcast_i;
          addr_d = cmd_addr_i;
          wd_d   = cmd_wdata_i;
          rw_d   = 1'b0;
          rd_d   = 1'b0;
          pair_d = 1'b0;
          unique case (host_cmd_e'(cmd_op_i))
            HC_READ:  begin opc_d = OPC_READ;  rw_d = 1'b1; rd_d = 1'b1; end
            HC_WRITE: begin opc_d = OPC_WRITE; rw_d = 1'b1; end
            HC_RSTPR: begin opc_d = OPC_SETR;  pair_d = 1'b1; end
            default:  opc_d = OPC_FAST;
          endcase
        end
      end
      ST_FRAME: begin
        if (cnt_q == FRAME_LAST) begin
          st_d  = ST_SHIFT;
          cnt_d = '0;
          pkt_d = PK_REQ;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (last_bit) begin
          cnt_d = '0;
          if (!last_pkt) begin
            pkt_d = pkt_q + 1'b1;
          end else if (rw_q) begin
            st_d = ST_IDLE;
          end else begin
            st_d     = ST_GAP;
            gap_load = 1'b1;
            gap_val  = (opc_q == OPC_SETR) ? GAP_L_LD : GAP_S_LD;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (gap_done) begin
          if (pair_q) begin
            pair_d = 1'b0;
            opc_d  = OPC_CLRR;
            st_d   = ST_FRAME;
            cnt_d  = '0;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      pkt_q  <= PK_REQ;
      opc_q  <= OPC_READ;
      dev_q  <= '0;
      bc_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rw_q   <= 1'b0;
      rd_q   <= 1'b0;
      pair_q <= 1'b0;
      rsp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      pkt_q  <= pkt_d;
      opc_q  <= opc_d;
      dev_q  <= dev_d;
      bc_q   <= bc_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rw_q   <= rw_d;
      rd_q   <= rd_d;
      pair_q <= pair_d;
      rsp_q  <= rsp_d;
    end
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign ser_cmd_o   = (st_q == ST_FRAME) && (cnt_q < FRAME_HI);
  assign ser_oe_o    = !rx_phase;
  assign ser_do_o    = (st_q == ST_SHIFT) && !rx_phase && cur_word[BIT_LAST - cnt_q];
  assign rsp_valid_o = rsp_q;

endmodule

// File: rtl/sctl_seq_chk.sv
module sctl_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid_i,
  input logic cmd_ready_o,
  input logic ser_cmd_o,
  input logic ser_do_o,
  input logic ser_oe_o,
  input logic rsp_valid_o
);

  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> (!ser_cmd_o && !ser_do_o && ser_oe_o));

  assert_frame_ones_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_cmd_o) |=> ser_cmd_o);

  assert_release_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_oe_o |-> !cmd_ready_o);

  assert_rsp_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

  assert_rsp_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> cmd_ready_o);

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

endmodule

bind sctl_seq sctl_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid_i (cmd_valid_i),
  .cmd_ready_o (cmd_ready_o),
  .ser_cmd_o   (ser_cmd_o),
  .ser_do_o    (ser_do_o),
  .ser_oe_o    (ser_oe_o),
  .rsp_valid_o (rsp_valid_o)
);

// File: tb/sctl_seq_tb.sv
`timescale 1ns/1ps
module sctl_seq_tb;

  localparam int NCAP = 80;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid_i;
  logic        cmd_ready_o;
  logic [1:0]  cmd_op_i;
  logic [5:0]  cmd_dev_i;
  logic        cmd_bcast_i;
  logic [11:0] cmd_addr_i;
  logic [15:0] cmd_wdata_i;
  logic        ser_cmd_o;
  logic        ser_do_o;
  logic        ser_oe_o;
  logic        ser_di_i;
  logic        rsp_valid_o;
  logic [15:0] rsp_data_o;

  int n_tests;
  int n_fail;

  logic cap_cmd [NCAP];
  logic cap_do  [NCAP];
  logic cap_oe  [NCAP];
  logic cap_rdy [NCAP];
  int          rv_cycle;
  int          rv_count;
  logic [15:0] rv_data;

  sctl_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
    .cmd_op_i(cmd_op_i), .cmd_dev_i(cmd_dev_i), .cmd_bcast_i(cmd_bcast_i),
    .cmd_addr_i(cmd_addr_i), .cmd_wdata_i(cmd_wdata_i), .ser_cmd_o(ser_cmd_o),
    .ser_do_o(ser_do_o), .ser_oe_o(ser_oe_o), .ser_di_i(ser_di_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] req_word(input logic [3:0] opc, input logic [5:0] dev, input logic bc);
    return {5'b0, dev[5], opc, bc, dev[4:0]};
  endfunction

  function automatic logic [15:0] do_word(input int base);
    logic [15:0] w;
    for (int j = 0; j < 16; j++) w[15-j] = cap_do[base+j];
    return w;
  endfunction

  function automatic logic [15:0] oe_word(input int base);
    logic [15:0] w;
    for (int j = 0; j < 16; j++) w[15-j] = cap_oe[base+j];
    return w;
  endfunction

  function automatic logic [7:0] frame_at(input int base);
    logic [7:0] w;
    for (int j = 0; j < 8; j++) w[7-j] = cap_cmd[base+j];
    return w;
  endfunction

  function automatic int first_ready();
    for (int k = 0; k < NCAP; k++) if (cap_rdy[k]) return k;
    return -1;
  endfunction

  function automatic int count_cmd(input int lo, input int hi);
    int c = 0;
    for (int k = lo; k <= hi; k++) if (cap_cmd[k] || cap_do[k]) c++;
    return c;
  endfunction

  // Issue a command and record NCAP cycles; cycle 0 follows the accepting edge.
  task automatic run_cmd(input logic [1:0] op, input logic [5:0] dev, input logic bc,
                         input logic [11:0] addr, input logic [15:0] wd,
                         input logic [15:0] rdword, input bit inject);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_dev_i = dev; cmd_bcast_i = bc;
    cmd_addr_i = addr; cmd_wdata_i = wd;
    @(posedge clk);
    rv_cycle = -1; rv_count = 0; rv_data = '0;
    for (int k = 0; k < NCAP; k++) begin
      @(negedge clk);
      cap_cmd[k] = ser_cmd_o; cap_do[k] = ser_do_o; cap_oe[k] = ser_oe_o; cap_rdy[k] = cmd_ready_o;
      if (rsp_valid_o) begin
        rv_count++;
        if (rv_cycle < 0) begin rv_cycle = k; rv_data = rsp_data_o; end
      end
      if (inject && k < 3) begin
        cmd_valid_i = 1'b1; cmd_op_i = 2'd1; cmd_dev_i = 6'h3F; cmd_wdata_i = 16'hFFFF;
      end else begin
        cmd_valid_i = 1'b0;
      end
      ser_di_i = (k >= 56 && k < 72) ? rdword[71-k] : 1'b0;
    end
  endtask

  task automatic t_reset_state();
    chk(cmd_ready_o == 1'b1, "R1 ready", cmd_ready_o, 1);
    chk({ser_cmd_o, ser_do_o, ser_oe_o} == 3'b001, "R1 serial idle", {ser_cmd_o, ser_do_o, ser_oe_o}, 1);
    chk(rsp_valid_o == 1'b0, "R1 rsp_valid", rsp_valid_o, 0);
  endtask

  task automatic t_write(input logic [5:0] dev, input logic bc, input logic [11:0] addr, input logic [15:0] wd);
    run_cmd(2'd1, dev, bc, addr, wd, 16'h0, 1'b0);
    chk(frame_at(0) == 8'hF0, "R2 write framing", frame_at(0), 8'hF0);
    chk(count_cmd(8, 71) == count_cmd(8, 71) && frame_at(8) == 8'h00 && frame_at(64) == 8'h00,
        "R2 cmd low after framing", frame_at(8), 0);
    chk(do_word(8) == req_word(4'b0001, dev, bc), "R3 R4 write request", do_word(8), req_word(4'b0001, dev, bc));
    chk(do_word(24) == {4'b0, addr}, "R5 address packet", do_word(24), {4'b0, addr});
    chk(do_word(40) == 16'h0, "R5 interval packet", do_word(40), 0);
    chk(do_word(56) == wd, "R5 write data", do_word(56), wd);
    chk(oe_word(56) == 16'hFFFF, "R5 write keeps drive", oe_word(56), 16'hFFFF);
    chk(first_ready() == 72, "R9 write ready cycle", first_ready(), 72);
    chk(rv_count == 0, "R6 no response on write", rv_count, 0);
  endtask

  task automatic t_read(input logic [5:0] dev, input logic [11:0] addr, input logic [15:0] rd);
    run_cmd(2'd0, dev, 1'b0, addr, 16'hFFFF, rd, 1'b0);
    chk(frame_at(0) == 8'hF0, "R2 read framing", frame_at(0), 8'hF0);
    chk(do_word(8) == req_word(4'b0000, dev, 1'b0), "R4 read request", do_word(8), req_word(4'b0000, dev, 1'b0));
    chk(do_word(24) == {4'b0, addr}, "R5 read address", do_word(24), {4'b0, addr});
    chk(oe_word(56) == 16'h0 && oe_word(40) == 16'hFFFF && cap_oe[72], "R6 release window", oe_word(56), 0);
    chk(do_word(56) == 16'h0, "R6 released line low", do_word(56), 0);
    chk(rv_cycle == 72, "R6 response cycle", rv_cycle, 72);
    chk(rv_count == 1, "R6 single pulse", rv_count, 1);
    chk(rv_data == rd, "R6 captured word", rv_data, rd);
    chk(first_ready() == 72, "R9 read ready cycle", first_ready(), 72);
  endtask

  task automatic t_fast_with_busy_offer();
    run_cmd(2'd3, 6'h15, 1'b1, 12'hABC, 16'h1234, 16'h0, 1'b1);
    chk(frame_at(0) == 8'hF0, "R2 fast framing", frame_at(0), 8'hF0);
    chk(do_word(8) == req_word(4'b0100, 6'h15, 1'b1), "R7 fast request", do_word(8), req_word(4'b0100, 6'h15, 1'b1));
    chk(count_cmd(24, 27) == 0, "R7 gap idle", count_cmd(24, 27), 0);
    chk(first_ready() == 28, "R7 ready after gap", first_ready(), 28);
    chk(count_cmd(28, NCAP-1) == 0, "R9 busy offer ignored", count_cmd(28, NCAP-1), 0);
    chk(cap_rdy[NCAP-1] == 1'b1, "R9 idle after ignored offer", cap_rdy[NCAP-1], 1);
  endtask

  task automatic t_reset_pair();
    run_cmd(2'd2, 6'h21, 1'b1, 12'h000, 16'h0, 16'h0, 1'b0);
    chk(frame_at(0) == 8'hF0, "R8 setr framing", frame_at(0), 8'hF0);
    chk(do_word(8) == req_word(4'b0010, 6'h21, 1'b1), "R8 R4 set-reset request", do_word(8), req_word(4'b0010, 6'h21, 1'b1));
    chk(count_cmd(24, 39) == 0, "R8 long gap", count_cmd(24, 39), 0);
    chk(frame_at(40) == 8'hF0, "R8 clrr framing", frame_at(40), 8'hF0);
    chk(do_word(48) == req_word(4'b1011, 6'h21, 1'b1), "R8 R4 clear-reset request", do_word(48), req_word(4'b1011, 6'h21, 1'b1));
    chk(count_cmd(64, 67) == 0, "R8 short gap", count_cmd(64, 67), 0);
    chk(first_ready() == 68, "R8 R9 ready cycle", first_ready(), 68);
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; cmd_valid_i = 1'b0; cmd_op_i = '0; cmd_dev_i = '0; cmd_bcast_i = 1'b0;
    cmd_addr_i = '0; cmd_wdata_i = '0; ser_di_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reset_pair();
    t_fast_with_busy_offer();
    t_write(6'h2A, 1'b0, 12'h5A3, 16'hC3A5);
    t_write(6'h01, 1'b1, 12'hFFF, 16'h8001);
    t_read(6'h3F, 12'h001, 16'hB00D);
    t_read(6'h00, 12'h800, 16'h0001);
    @(negedge clk);
    t_reset_state();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule